// File: doc/BRIEF.md
# Predicated Paired-Doubleword Deinterleaving Load Unit

This unit performs one contiguous load of two-doubleword structures into two vector destinations. A start strobe supplies a 64-bit base, a signed 4-bit immediate, a per-lane predicate mask and a destination register number. The unit forms a start address by scaling the immediate by the combined size of both destination vectors. It then walks memory one doubleword at a time through a single-outstanding read port. Within each structure, the first doubleword goes to vector A and the second to vector B, both in the same lane.

A lane whose predicate bit is clear is filled with zero in both vectors. No read is issued for it, but the address still moves past its two doublewords. When the base is flagged as the stack pointer and at least one lane is active, the base must be 16-byte aligned. Otherwise the load aborts with a fault and writes nothing. When all lanes have been handled, both vectors and their register numbers are presented with a one-cycle write strobe and a done pulse.

Back-pressure rules: `req_valid` with `req_addr` is held stable until `req_ready` is high at a clock edge. After that handshake, no new request is raised until one `rsp_valid` beat has delivered `rsp_data`. Responses cannot be stalled. A `rsp_valid` that arrives while no request is outstanding is ignored. `start` is sampled only while the unit is idle.

Top module: `ld2_deint_unit`

## Requirements
- R1: The start address is base + sext(imm) × (VLEN/64) × 16, modulo 2^64, where imm is the 4-bit two's-complement `imm` input.
- R2: Doubleword k (k = 0 … 2·VLEN/64−1) is at start address + 8k. An even k lands in `vec_a` and an odd k lands in `vec_b`, both in lane k/2. Lane e occupies bits [64e+63:64e].
- R3: A lane whose `pred` bit (bit e for lane e) is 0 reads as zero in both vectors, and no request is made for its two doublewords.
- R4: `idx_a` equals the captured `dst_idx`, and `idx_b` is (`dst_idx`+1) mod 32, so 31 is followed by 0.
- R5: If `use_sp` is 1, `pred` has any bit set and base[3:0] is not zero, then `fault` and `done` pulse together in the cycle after `start`. No request is made and `wr_en` stays 0. With `use_sp` at 0, or with `pred` all zero, there is no fault.
- R6: A request stays valid with a stable address until accepted. At most one request is outstanding at a time.
- R7: After the last lane, `wr_en` and `done` pulse high for one cycle together, with the final `vec_a`, `vec_b`, `idx_a` and `idx_b`. A load that does not fault raises neither signal in the cycle after `start`.
- R8: A `start` that arrives while a load is in progress has no effect on that load's addresses or results.
- R9: An all-zero predicate completes with both vectors zero and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (sampled when idle) |
| use_sp | input | 1 | Base comes from the stack pointer; enables the alignment check |
| base | input | 64 | Base address |
| imm | input | 4 | Signed immediate, in units of the two-vector footprint |
| pred | input | VLEN/64 | Lane predicate, bit e governs lane e |
| dst_idx | input | 5 | First destination register number |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 64 | Read request byte address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 64 | Read data |
| wr_en | output | 1 | Destination write strobe |
| vec_a | output | VLEN | First destination vector |
| vec_b | output | VLEN | Second destination vector |
| idx_a | output | 5 | First destination register number |
| idx_b | output | 5 | Second destination register number |
| done | output | 1 | Load finished (completed or faulted) |
| fault | output | 1 | Stack-pointer alignment fault |

## Verification
Some properties are checked on every cycle by assertions. These are the request hold under back-pressure, the single outstanding read, single-cycle `done`, the pairing of `wr_en` with `done`, and a fault appearing only after `start` and never together with a write. The bench's scenarios cover what only end-to-end stimulus can show. That includes the scaled and wrapped start address, the exact address sequence with skipped inactive lanes, the even/odd deinterleave and zero-fill, register-number wrap, the conditions that do and do not raise the alignment fault, and a second `start` during a busy load having no effect.

// File: rtl/ld2_pkg.sv
package ld2_pkg;
  localparam int ELEM_W     = 64;
  localparam int BEAT_BYTES = ELEM_W / 8;
  localparam int REGS       = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } ld2_state_e;
endpackage

// File: rtl/ld2_addr_gen.sv
module ld2_addr_gen #(
  parameter int NEL = 4
) (
  input  logic [63:0]    base,
  input  logic [3:0]     imm,
  input  logic           use_sp,
  input  logic [NEL-1:0] pred,
  output logic [63:0]    start_addr,
  output logic           align_fault
);
  localparam int FOOTPRINT = NEL * ld2_pkg::REGS * ld2_pkg::BEAT_BYTES;

  logic [63:0] imm_ext;

  always_comb begin
    imm_ext     = {{60{imm[3]}}, imm};
    // product and sum both wrap modulo 2^64
    start_addr  = base + imm_ext * 64'(FOOTPRINT);
    align_fault = use_sp && (|pred) && (base[3:0] != 4'd0);
  end
endmodule

// File: rtl/ld2_lane_buf.sv
module ld2_lane_buf #(
  parameter int NEL = 4,
  localparam int LW = (NEL > 1) ? $clog2(NEL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [LW-1:0]     lane,
  input  logic              sel_b,
  input  logic [63:0]       data,
  output logic [NEL*64-1:0] vec_a,
  output logic [NEL*64-1:0] vec_b
);
  for (genvar e = 0; e < NEL; e++) begin : g_lane
    logic [63:0] a_q, b_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        a_q <= '0;
        b_q <= '0;
      end else if (wr && lane == LW'(e)) begin
        if (sel_b) b_q <= data;
        else       a_q <= data;
      end
    end
    assign vec_a[e*64 +: 64] = a_q;
    assign vec_b[e*64 +: 64] = b_q;
  end
endmodule

// File: rtl/ld2_deint_unit.sv
module ld2_deint_unit
  import ld2_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_sp,
  input  logic [63:0]       base,
  input  logic [3:0]        imm,
  input  logic [VLEN/64-1:0] pred,
  input  logic [4:0]        dst_idx,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [63:0]       req_addr,
  input  logic              rsp_valid,
  input  logic [63:0]       rsp_data,
  output logic              wr_en,
  output logic [VLEN-1:0]   vec_a,
  output logic [VLEN-1:0]   vec_b,
  output logic [4:0]        idx_a,
  output logic [4:0]        idx_b,
  output logic              done,
  output logic              fault
);
  localparam int NEL   = VLEN / ELEM_W;
  localparam int TOTAL = REGS * NEL;
  localparam int BW    = $clog2(TOTAL + 1);
  localparam int LW    = (NEL > 1) ? $clog2(NEL) : 1;
  localparam logic [63:0] STRUCT_BYTES = 64'(REGS * BEAT_BYTES);

  ld2_state_e     state;
  logic [BW-1:0]  beat;
  logic [63:0]    cur_addr;
  logic [NEL-1:0] pred_q;
  logic [4:0]     idx_q;
  logic           wr_q, done_q, fault_q;

  logic [63:0]    start_addr;
  logic           align_fault;
  logic [LW-1:0]  lane;
  logic           at_end, lane_on, accept, clr_buf, buf_wr;

  ld2_addr_gen #(.NEL(NEL)) u_agen (
    .base        (base),
    .imm         (imm),
    .use_sp      (use_sp),
    .pred        (pred),
    .start_addr  (start_addr),
    .align_fault (align_fault)
  );

  always_comb begin
    lane    = LW'(beat >> 1);
    at_end  = (beat == BW'(TOTAL));
    lane_on = !at_end && pred_q[lane];
    accept  = (state == ST_IDLE) && start;
    clr_buf = accept && !align_fault;
    buf_wr  = (state == ST_WAIT) && rsp_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat     <= '0;
      cur_addr <= '0;
      pred_q   <= '0;
      idx_q    <= '0;
      wr_q     <= 1'b0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (align_fault) begin
              fault_q <= 1'b1;
              done_q  <= 1'b1;
            end else begin
              state    <= ST_RUN;
              beat     <= '0;
              cur_addr <= start_addr;
              pred_q   <= pred;
              idx_q    <= dst_idx;
            end
          end
        end
        ST_RUN: begin
          if (at_end) begin
            state  <= ST_IDLE;
            wr_q   <= 1'b1;
            done_q <= 1'b1;
          end else if (!lane_on) begin
            // skip both doublewords of an inactive lane in one cycle
            beat     <= beat + BW'(REGS);
            cur_addr <= cur_addr + STRUCT_BYTES;
          end else if (req_ready) begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            beat     <= beat + BW'(1);
            cur_addr <= cur_addr + 64'(BEAT_BYTES);
            state    <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  ld2_lane_buf #(.NEL(NEL)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_buf),
    .wr    (buf_wr),
    .lane  (lane),
    .sel_b (beat[0]),
    .data  (rsp_data),
    .vec_a (vec_a),
    .vec_b (vec_b)
  );

  assign req_valid = (state == ST_RUN) && lane_on;
  assign req_addr  = cur_addr;
  assign wr_en     = wr_q;
  assign done      = done_q;
  assign fault     = fault_q;
  assign idx_a     = idx_q;
  assign idx_b     = idx_q + 5'd1;
endmodule

// File: rtl/ld2_deint_chk.sv
module ld2_deint_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_addr,
  input logic        rsp_valid,
  input logic        wr_en,
  input logic        done,
  input logic        fault
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n)                      outstanding <= 1'b0;
    else if (req_valid && req_ready) outstanding <= 1'b1;
    else if (rsp_valid)              outstanding <= 1'b0;
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R6
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !req_valid);

  // R7
  wr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  fault_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(start) && !wr_en);
endmodule

bind ld2_deint_unit ld2_deint_chk u_chk (.*);

// File: tb/ld2_deint_unit_tb.sv
`timescale 1ns/1ps
module ld2_deint_unit_tb;
  localparam int VLEN = 256;
  localparam int NEL  = VLEN / 64;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              start = 1'b0, use_sp = 1'b0;
  logic [63:0]       base = '0;
  logic [3:0]        imm = '0;
  logic [NEL-1:0]    pred = '0;
  logic [4:0]        dst_idx = '0;
  logic              req_valid, req_ready = 1'b0;
  logic [63:0]       req_addr;
  logic              rsp_valid = 1'b0;
  logic [63:0]       rsp_data = '0;
  logic              wr_en, done, fault;
  logic [VLEN-1:0]   vec_a, vec_b;
  logic [4:0]        idx_a, idx_b;

  int checks = 0, fails = 0;
  int ready_mod = 1, lat = 0, cyc = 0;
  logic [63:0] exp_q[$];
  bit          pend = 0;
  int          dly = 0;
  logic [63:0] p_addr;

  ld2_deint_unit #(.VLEN(VLEN)) u_dut (.*);

  always #4 clk = ~clk;

  function automatic logic [63:0] mem_word(logic [63:0] a);
    return {a[31:0] ^ 32'hC0DE_0000, ~a[31:0]};
  endfunction

  task automatic chk(string tag, string what, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model and per-cycle request monitor
  always @(negedge clk) begin
    cyc++;
    req_ready = (ready_mod <= 1) ? 1'b1 : ((cyc % ready_mod) != 0);
    rsp_valid = 1'b0;
    if (pend) begin
      if (dly == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = mem_word(p_addr);
        pend      = 0;
      end else dly--;
    end
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) chk("R3", "unexpected request", VLEN'(req_addr), '0);
      else begin
        chk("R2", "request address", VLEN'(req_addr), VLEN'(exp_q[0]));
        void'(exp_q.pop_front());
      end
      pend   = 1;
      dly    = lat;
      p_addr = req_addr;
    end
  end

  task automatic run_load(string tag, logic [63:0] b, logic sp, logic [3:0] im,
                          logic [NEL-1:0] p, logic [4:0] ix, int rm, int lt, bit poke);
    logic [VLEN-1:0] ea, eb;
    logic [63:0] a0, a;
    longint off;
    bit ef;
    int n;
    ef  = sp && (|p) && (b[3:0] != 4'd0);
    off = longint'($signed(im)) * NEL * 16;
    a0  = b + 64'(off);
    ea  = '0;
    eb  = '0;
    for (int e = 0; e < NEL; e++) begin
      for (int r = 0; r < 2; r++) begin
        a = a0 + 64'(16 * e + 8 * r);
        if (p[e] && !ef) begin
          exp_q.push_back(a);
          if (r == 0) ea[e*64 +: 64] = mem_word(a);
          else        eb[e*64 +: 64] = mem_word(a);
        end
      end
    end
    ready_mod = rm;
    lat       = lt;
    @(negedge clk);
    base = b; use_sp = sp; imm = im; pred = p; dst_idx = ix; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(ef ? "R5" : "R7", {tag, " fault after start"}, VLEN'(fault), VLEN'(ef));
    chk(ef ? "R5" : "R7", {tag, " done after start"}, VLEN'(done), VLEN'(ef));
    if (ef) begin
      chk("R5", {tag, " no write on fault"}, VLEN'(wr_en), '0);
      repeat (4) @(negedge clk);
      #1;
      chk("R5", {tag, " no write later"}, VLEN'(wr_en), '0);
      return;
    end
    if (poke) begin
      @(negedge clk);
      base = ~b; pred = '1; dst_idx = ~ix; imm = ~im; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1;
    end
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      #1;
      n++;
    end
    if (n >= 2000) chk("R7", {tag, " completion timeout"}, '0, 1);
    else begin
      chk("R7", {tag, " wr_en at done"}, VLEN'(wr_en), 1);
      chk(poke ? "R8" : "R2", {tag, " vec_a"}, vec_a, ea);
      chk(poke ? "R8" : "R2", {tag, " vec_b"}, vec_b, eb);
      chk("R4", {tag, " idx_a"}, VLEN'(idx_a), VLEN'(ix));
      chk("R4", {tag, " idx_b"}, VLEN'(idx_b), VLEN'(5'(ix + 5'd1)));
      chk("R1", {tag, " all requests issued"}, VLEN'(exp_q.size()), '0);
    end
    @(negedge clk);
    #1;
    chk("R7", {tag, " done single pulse"}, VLEN'(done), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R7", "reset wr_en", VLEN'(wr_en), '0);
    chk("R7", "reset done", VLEN'(done), '0);
    chk("R5", "reset fault", VLEN'(fault), '0);
    chk("R6", "reset req_valid", VLEN'(req_valid), '0);
    // R1 R2: all lanes, zero immediate
    run_load("t1", 64'h1000, 1'b0, 4'd0, 4'b1111, 5'd3, 1, 0, 0);
    // R1 R3 R4: negative immediate, sparse lanes, index wrap, back-pressure
    run_load("t2", 64'h2000_0000_0000_0100, 1'b0, 4'b1110, 4'b0101, 5'd31, 3, 2, 0);
    // R9: no active lanes
    run_load("t3", 64'h4000, 1'b0, 4'b0111, 4'b0000, 5'd10, 1, 0, 0);
    // R5: misaligned stack pointer with an active lane
    run_load("t4", 64'h8008, 1'b1, 4'd2, 4'b0010, 5'd4, 1, 0, 0);
    // R5 R9: misaligned stack pointer, no active lane
    run_load("t5", 64'h8008, 1'b1, 4'd2, 4'b0000, 5'd5, 1, 0, 0);
    // R1: aligned stack pointer, address wraps below zero
    run_load("t6", 64'h40, 1'b1, 4'b1000, 4'b1110, 5'd30, 2, 1, 0);
    // R8: second start while busy
    run_load("t7", 64'h0123_4560, 1'b0, 4'd1, 4'b1111, 5'd7, 2, 3, 1);
    // R5: misaligned plain register base needs no alignment
    run_load("t8", 64'h9007, 1'b0, 4'd0, 4'b1001, 5'd0, 1, 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule